// File: doc/BRIEF.md
# Trap entry sequencer

This block applies the architectural state changes that happen when a processor takes a trap. A one-cycle strobe arrives with a 9-bit trap type and a snapshot of the current trap level, processor-state word, window pointer, spill budget, global level, PC, next PC and the two trap base registers. One clock later the block presents the new trap level, processor-state word, window pointer, global level, PC and next PC. In the same cycle it emits a trap stack write, indexed by the new level, that saves the pre-trap context.

When the trap level is already at or past the maximum, the trap cannot be taken. The block then raises an error pulse in place of the done pulse and writes nothing. When the last usable level is consumed, the block sets the red-state bit. The vector address comes from the normal trap base or, in hypervisor mode, from the hyper trap base.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is low, every output is zero.
- R2: A strobe with `cur_tl` >= MAXTL (default 6) produces `err` high for one cycle, with `done` and `ts_we` low. All `new_*` and `ts_*` outputs keep their previous values.
- R3: A strobe with `cur_tl` < MAXTL gives `new_tl` = `cur_tl`+1. The red-state bit (bit 5 of `new_pstate`) is set exactly when `cur_tl` equals MAXTL-1.
- R4: A taken trap writes the stack. `ts_we` is high, `ts_idx` is the new level, `ts_state` is {`cur_gl`, `cur_pstate`, `cur_cwp`} with the global level in the top bits, and `ts_pc`, `ts_npc` and `ts_tt` are the incoming PC, next PC and trap type.
- R5: On a taken trap `new_pstate` has only these bits set: bit 4 (FPU enable), bit 2 (privileged), bit 5 when R3 calls for it, and exactly one globals-select bit. That bit is bit 10 for types 0x008, 0x030 and 0x064..0x06F, bit 11 for type 0x060, and bit 0 for every other type.
- R6: Type 0x024 (clean window) gives `new_cwp` = `cur_cwp`-1, modulo NWIN (default 8).
- R7: Types 0x080..0x0BF (spill) give `new_cwp` = `cur_cwp`-`cur_cansave`-2, modulo NWIN.
- R8: Types 0x0C0..0x0FF (fill) give `new_cwp` = `cur_cwp`+1, modulo NWIN. Every other type leaves the window pointer unchanged.
- R9: With `hyper_mode` low, `new_pc` is `tba` with bits 14:0 cleared, OR bit 14 when the new level exceeds 1, OR the trap type shifted left by 5.
- R10: With `hyper_mode` high, `new_pc` is `htba` with bits 13:0 cleared, OR the trap type shifted left by 5.
- R11: `new_npc` equals `new_pc` + 4.
- R12: With the global-level option on (default), `new_gl` = `cur_gl`+1, wrapping at the field width.
- R13: Outputs change only in the cycle after a strobe. `done` pulses for one cycle per taken trap, and with no strobe `done`, `err` and `ts_we` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_go | input | 1 | Trap-taken strobe |
| trap_type | input | 9 | Trap type of the trap being taken |
| hyper_mode | input | 1 | Select the hyper trap base for the vector |
| cur_tl | input | 3 | Current trap level |
| cur_pstate | input | 12 | Current processor-state word |
| cur_cwp | input | 3 | Current window pointer |
| cur_cansave | input | 3 | Current count of windows that can be saved |
| cur_gl | input | 3 | Current global level |
| cur_pc | input | 64 | PC at the trap |
| cur_npc | input | 64 | Next PC at the trap |
| tba | input | 64 | Normal trap base register |
| htba | input | 64 | Hyper trap base register |
| ts_we | output | 1 | Trap stack write enable |
| ts_idx | output | 3 | Trap stack entry index |
| ts_state | output | 18 | Saved state word |
| ts_pc | output | 64 | Saved PC |
| ts_npc | output | 64 | Saved next PC |
| ts_tt | output | 9 | Saved trap type |
| new_tl | output | 3 | Updated trap level |
| new_pstate | output | 12 | Updated processor-state word |
| new_cwp | output | 3 | Updated window pointer |
| new_gl | output | 3 | Updated global level |
| new_pc | output | 64 | Trap vector address |
| new_npc | output | 64 | Trap vector address plus 4 |
| done | output | 1 | Trap entry complete pulse |
| err | output | 1 | Trap level overflow pulse |

## Verification
The bench walks the trap level through every value, including MAXTL-1 and both levels above the maximum. An off-by-one in the level compare would either take a trap it must refuse, with a stack write past the top, or set the red bit one level early. Window traps are driven with pointer 0 for clean windows, pointer 7 for fills and large spill budgets for spills. A design without modular wrap would produce out-of-range or negative-carrying pointers. Each MMU class boundary (0x064, 0x06F), the interrupt vector type and neighbouring ordinary types are applied, so a decode range that is one too wide or too narrow shows up as the wrong globals bit. Both vector modes are exercised at levels 1 and 2, which catches a level-above-one bit that is missing or wrongly added in hypervisor mode.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   localparam int TTW  = 9;
   localparam int PS_W = 12;

   // processor-state bit positions
   localparam int PS_AG   = 0;
   localparam int PS_IE   = 1;
   localparam int PS_PRIV = 2;
   localparam int PS_PEF  = 4;
   localparam int PS_RED  = 5;
   localparam int PS_MG   = 10;
   localparam int PS_IG   = 11;

   // trap type codes used by the class decode
   localparam logic [TTW-1:0] TT_IFAULT = 9'h008;
   localparam logic [TTW-1:0] TT_CLEAN  = 9'h024;
   localparam logic [TTW-1:0] TT_DFAULT = 9'h030;
   localparam logic [TTW-1:0] TT_IVEC   = 9'h060;
   localparam logic [6:0]     TT_IMISS4 = 7'h19;  // 0x064..0x067
   localparam logic [6:0]     TT_DMISS4 = 7'h1A;  // 0x068..0x06B
   localparam logic [6:0]     TT_DPROT4 = 7'h1B;  // 0x06C..0x06F
   localparam logic [2:0]     TT_SPILL8 = 3'b010; // 0x080..0x0BF
   localparam logic [2:0]     TT_FILL8  = 3'b011; // 0x0C0..0x0FF

   typedef enum logic [1:0] {GS_ALT, GS_MMU, GS_INT} gsel_e;
   typedef enum logic [1:0] {WK_NONE, WK_CLEAN, WK_SPILL, WK_FILL} wkind_e;

   function automatic gsel_e globals_of(input logic [TTW-1:0] tt);
      gsel_e g;
      if (tt == TT_IFAULT || tt == TT_DFAULT ||
          tt[8:2] == TT_IMISS4 || tt[8:2] == TT_DMISS4 || tt[8:2] == TT_DPROT4)
         g = GS_MMU;
      else if (tt == TT_IVEC)
         g = GS_INT;
      else
         g = GS_ALT;
      return g;
   endfunction

   function automatic wkind_e window_of(input logic [TTW-1:0] tt);
      wkind_e k;
      if (tt == TT_CLEAN)
         k = WK_CLEAN;
      else if (tt[8:6] == TT_SPILL8)
         k = WK_SPILL;
      else if (tt[8:6] == TT_FILL8)
         k = WK_FILL;
      else
         k = WK_NONE;
      return k;
   endfunction

endpackage

// File: rtl/trap_level_step.sv
module trap_level_step #(
   parameter int MAXTL = 6,
   parameter int TLW   = 3
) (
   input  logic [TLW-1:0] cur_tl,
   output logic [TLW-1:0] nxt_tl,
   output logic           red,
   output logic           ovf
);
   localparam logic [TLW-1:0] TL_TOP  = TLW'(MAXTL);
   localparam logic [TLW-1:0] TL_EDGE = TLW'(MAXTL - 1);

   always_comb begin
      ovf    = (cur_tl >= TL_TOP);
      red    = (cur_tl == TL_EDGE);
      nxt_tl = ovf ? cur_tl : cur_tl + 1'b1;
   end
endmodule

// File: rtl/trap_window_step.sv
module trap_window_step
   import trap_entry_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int CWW  = 3
) (
   input  logic [CWW-1:0] cur_cwp,
   input  logic [CWW-1:0] cansave,
   input  wkind_e         kind,
   output logic [CWW-1:0] nxt_cwp
);
   localparam int EW = CWW + 3;
   localparam logic [EW-1:0] OFF_CLEAN = EW'(NWIN - 1);
   localparam logic [EW-1:0] OFF_SPILL = EW'(2 * NWIN - 2);

   logic [EW-1:0] base;

   always_comb begin
      case (kind)
         WK_CLEAN: base = EW'(cur_cwp) + OFF_CLEAN;
         WK_SPILL: base = EW'(cur_cwp) + OFF_SPILL - EW'(cansave);
         WK_FILL:  base = EW'(cur_cwp) + EW'(1);
         default:  base = EW'(cur_cwp);
      endcase
   end

   generate
      if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
         assign nxt_cwp = base[CWW-1:0];
      end else begin : g_mod
         assign nxt_cwp = CWW'(base % EW'(NWIN));
      end
   endgenerate
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
   import trap_entry_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic           hyper,
   input  logic           upper,
   input  logic [AW-1:0]  tba,
   input  logic [AW-1:0]  htba,
   input  logic [TTW-1:0] tt,
   output logic [AW-1:0]  pc,
   output logic [AW-1:0]  npc
);
   localparam logic [AW-1:0] N_MASK = ~{{(AW-15){1'b0}}, 15'h7FFF};
   localparam logic [AW-1:0] H_MASK = ~{{(AW-14){1'b0}}, 14'h3FFF};
   localparam logic [AW-1:0] UP_BIT = {{(AW-15){1'b0}}, 15'h4000};

   logic [AW-1:0] off;

   always_comb begin
      off = {{(AW-TTW-5){1'b0}}, tt, 5'b00000};
      if (hyper)
         pc = (htba & H_MASK) | off;
      else
         pc = (tba & N_MASK) | off | (upper ? UP_BIT : '0);
      npc = pc + AW'(4);
   end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_entry_pkg::*;
#(
   parameter int AW    = 64,
   parameter int MAXTL = 6,
   parameter int NWIN  = 8,
   parameter int GLW   = 3,
   parameter bit GL_EN = 1'b1,
   localparam int TLW  = $clog2(MAXTL + 1),
   localparam int CWW  = $clog2(NWIN),
   localparam int SW   = GLW + PS_W + CWW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_go,
   input  logic [TTW-1:0]   trap_type,
   input  logic             hyper_mode,
   input  logic [TLW-1:0]   cur_tl,
   input  logic [PS_W-1:0]  cur_pstate,
   input  logic [CWW-1:0]   cur_cwp,
   input  logic [CWW-1:0]   cur_cansave,
   input  logic [GLW-1:0]   cur_gl,
   input  logic [AW-1:0]    cur_pc,
   input  logic [AW-1:0]    cur_npc,
   input  logic [AW-1:0]    tba,
   input  logic [AW-1:0]    htba,
   output logic             ts_we,
   output logic [TLW-1:0]   ts_idx,
   output logic [SW-1:0]    ts_state,
   output logic [AW-1:0]    ts_pc,
   output logic [AW-1:0]    ts_npc,
   output logic [TTW-1:0]   ts_tt,
   output logic [TLW-1:0]   new_tl,
   output logic [PS_W-1:0]  new_pstate,
   output logic [CWW-1:0]   new_cwp,
   output logic [GLW-1:0]   new_gl,
   output logic [AW-1:0]    new_pc,
   output logic [AW-1:0]    new_npc,
   output logic             done,
   output logic             err
);
   // elaboration-time parameter checks
   generate
      if (MAXTL < 2)  begin : g_bad_tl  $error("MAXTL must be at least 2");  end
      if (NWIN < 2)   begin : g_bad_win $error("NWIN must be at least 2");   end
      if (AW < 16)    begin : g_bad_aw  $error("AW must be at least 16");    end
      if (GLW < 1)    begin : g_bad_gl  $error("GLW must be at least 1");    end
   endgenerate

   logic [TLW-1:0]  tl_nx;
   logic            red_nx, ovf;
   logic [CWW-1:0]  cwp_nx;
   logic [AW-1:0]   pc_nx, npc_nx;
   logic [PS_W-1:0] ps_nx;
   logic [GLW-1:0]  gl_nx;
   gsel_e           gsel;
   wkind_e          wkind;
   logic            take;

   assign gsel  = globals_of(trap_type);
   assign wkind = window_of(trap_type);
   assign take  = trap_go && !ovf;

   trap_level_step #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
      .cur_tl (cur_tl),
      .nxt_tl (tl_nx),
      .red    (red_nx),
      .ovf    (ovf)
   );

   trap_window_step #(.NWIN(NWIN), .CWW(CWW)) u_window (
      .cur_cwp (cur_cwp),
      .cansave (cur_cansave),
      .kind    (wkind),
      .nxt_cwp (cwp_nx)
   );

   trap_vector_gen #(.AW(AW)) u_vector (
      .hyper (hyper_mode),
      .upper (tl_nx > TLW'(1)),
      .tba   (tba),
      .htba  (htba),
      .tt    (trap_type),
      .pc    (pc_nx),
      .npc   (npc_nx)
   );

   always_comb begin
      ps_nx          = '0;
      ps_nx[PS_PEF]  = 1'b1;
      ps_nx[PS_PRIV] = 1'b1;
      ps_nx[PS_RED]  = red_nx;
      case (gsel)
         GS_MMU:  ps_nx[PS_MG] = 1'b1;
         GS_INT:  ps_nx[PS_IG] = 1'b1;
         default: ps_nx[PS_AG] = 1'b1;
      endcase
   end

   generate
      if (GL_EN) begin : g_gl_step
         assign gl_nx = cur_gl + 1'b1;
      end else begin : g_gl_hold
         assign gl_nx = cur_gl;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_we      <= 1'b0;
         ts_idx     <= '0;
         ts_state   <= '0;
         ts_pc      <= '0;
         ts_npc     <= '0;
         ts_tt      <= '0;
         new_tl     <= '0;
         new_pstate <= '0;
         new_cwp    <= '0;
         new_gl     <= '0;
         new_pc     <= '0;
         new_npc    <= '0;
         done       <= 1'b0;
         err        <= 1'b0;
      end else begin
         done  <= take;
         err   <= trap_go && ovf;
         ts_we <= take;
         if (take) begin
            ts_idx     <= tl_nx;
            ts_state   <= {cur_gl, cur_pstate, cur_cwp};
            ts_pc      <= cur_pc;
            ts_npc     <= cur_npc;
            ts_tt      <= trap_type;
            new_tl     <= tl_nx;
            new_pstate <= ps_nx;
            new_cwp    <= cwp_nx;
            new_gl     <= gl_nx;
            new_pc     <= pc_nx;
            new_npc    <= npc_nx;
         end
      end
   end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
   import trap_entry_pkg::*;
#(
   parameter int AW    = 64,
   parameter int MAXTL = 6,
   parameter int NWIN  = 8,
   parameter int GLW   = 3,
   localparam int TLW  = $clog2(MAXTL + 1),
   localparam int CWW  = $clog2(NWIN),
   localparam int SW   = GLW + PS_W + CWW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trap_go,
   input logic [TTW-1:0]   trap_type,
   input logic [TLW-1:0]   cur_tl,
   input logic             ts_we,
   input logic [TLW-1:0]   ts_idx,
   input logic [TTW-1:0]   ts_tt,
   input logic [TLW-1:0]   new_tl,
   input logic [PS_W-1:0]  new_pstate,
   input logic [AW-1:0]    new_pc,
   input logic [AW-1:0]    new_npc,
   input logic             done,
   input logic             err
);
   localparam logic [TLW-1:0] TL_TOP  = TLW'(MAXTL);
   localparam logic [TLW-1:0] TL_EDGE = TLW'(MAXTL - 1);

   AST_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_go && cur_tl >= TL_TOP |=> err && !done && !ts_we); // R2
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      trap_go && cur_tl >= TL_TOP |=> new_tl == $past(new_tl)); // R2
   AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_go && cur_tl < TL_TOP |=> new_tl == $past(cur_tl) + 1'b1); // R3
   AST_RED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_go && cur_tl == TL_EDGE |=> new_pstate[PS_RED]); // R3
   AST_STACK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      ts_we |-> ts_idx == new_tl); // R4
   AST_TT_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
      trap_go && cur_tl < TL_TOP |=> ts_tt == $past(trap_type)); // R4
   AST_ONE_GLOBALS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({new_pstate[PS_AG], new_pstate[PS_MG], new_pstate[PS_IG]}) == 1
               && new_pstate[PS_PRIV] && new_pstate[PS_PEF]); // R5
   AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> new_pc[4:0] == 5'd0); // R9
   AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> new_npc == new_pc + AW'(4)); // R11
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_go |=> !done && !err && !ts_we); // R13
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R13
endmodule

bind trap_entry_seq trap_entry_chk #(
   .AW(AW), .MAXTL(MAXTL), .NWIN(NWIN), .GLW(GLW)
) u_chk (.*);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;
   localparam int MAXTL      = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_go = 1'b0;
   logic [8:0]  trap_type = '0;
   logic        hyper_mode = 1'b0;
   logic [2:0]  cur_tl = '0;
   logic [11:0] cur_pstate = '0;
   logic [2:0]  cur_cwp = '0, cur_cansave = '0, cur_gl = '0;
   logic [63:0] cur_pc = '0, cur_npc = '0, tba = '0, htba = '0;

   logic        ts_we, done, err;
   logic [2:0]  ts_idx, new_tl, new_cwp, new_gl;
   logic [17:0] ts_state;
   logic [63:0] ts_pc, ts_npc, new_pc, new_npc;
   logic [8:0]  ts_tt;
   logic [11:0] new_pstate;

   trap_entry_seq u_trap_entry_seq (.*);

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit started = 0;

   // reference model state
   logic        m_we = 0, m_done = 0, m_err = 0;
   logic [2:0]  m_idx = 0, m_tl = 0, m_cwp = 0, m_gl = 0;
   logic [17:0] m_state = 0;
   logic [63:0] m_tpc = 0, m_tnpc = 0, m_pc = 0, m_npc = 0;
   logic [8:0]  m_tt = 0;
   logic [11:0] m_ps = 0;
   string       cwp_tag = "R8", pc_tag = "R9";
   int          c, tln;

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_we = 0; m_done = 0; m_err = 0; m_idx = 0; m_tl = 0; m_cwp = 0; m_gl = 0;
         m_state = 0; m_tpc = 0; m_tnpc = 0; m_pc = 0; m_npc = 0; m_tt = 0; m_ps = 0;
      end else begin
         m_we = 0; m_done = 0; m_err = 0;
         if (trap_go) begin
            if (int'(cur_tl) >= MAXTL) begin
               m_err = 1;
            end else begin
               tln = int'(cur_tl) + 1;
               m_done = 1; m_we = 1;
               m_idx = 3'(tln); m_tl = 3'(tln);
               m_state = {cur_gl, cur_pstate, cur_cwp};
               m_tpc = cur_pc; m_tnpc = cur_npc; m_tt = trap_type;
               m_ps = 12'h014;
               if (int'(cur_tl) == MAXTL - 1) m_ps[5] = 1'b1;
               if (trap_type == 9'h008 || trap_type == 9'h030 ||
                   (trap_type >= 9'h064 && trap_type <= 9'h06F)) m_ps[10] = 1'b1;
               else if (trap_type == 9'h060) m_ps[11] = 1'b1;
               else m_ps[0] = 1'b1;
               c = int'(cur_cwp);
               if (trap_type == 9'h024) begin c = c - 1; cwp_tag = "R6"; end
               else if (trap_type >= 9'h080 && trap_type < 9'h0C0) begin
                  c = c - int'(cur_cansave) - 2; cwp_tag = "R7";
               end else if (trap_type >= 9'h0C0 && trap_type < 9'h100) begin
                  c = c + 1; cwp_tag = "R8";
               end else cwp_tag = "R8";
               c = ((c % 8) + 8) % 8;
               m_cwp = 3'(c);
               m_gl = cur_gl + 3'd1;
               if (hyper_mode) begin
                  m_pc = (htba & ~64'h3FFF) | (64'(trap_type) << 5);
                  pc_tag = "R10";
               end else begin
                  m_pc = (tba & ~64'h7FFF) | (64'(trap_type) << 5) |
                         ((tln > 1) ? 64'h4000 : 64'h0);
                  pc_tag = "R9";
               end
               m_npc = m_pc + 64'd4;
            end
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string t(input string tag);
      return rst_n ? tag : "R1";
   endfunction

   always @(negedge clk) begin
      if (started) begin
         chk(t("R13"), "done",     64'(done),       64'(m_done));
         chk(t("R2"),  "err",      64'(err),        64'(m_err));
         chk(t("R4"),  "ts_we",    64'(ts_we),      64'(m_we));
         chk(t("R4"),  "ts_idx",   64'(ts_idx),     64'(m_idx));
         chk(t("R4"),  "ts_state", 64'(ts_state),   64'(m_state));
         chk(t("R4"),  "ts_pc",    ts_pc,           m_tpc);
         chk(t("R4"),  "ts_npc",   ts_npc,          m_tnpc);
         chk(t("R4"),  "ts_tt",    64'(ts_tt),      64'(m_tt));
         chk(t("R3"),  "new_tl",   64'(new_tl),     64'(m_tl));
         chk(t("R5"),  "pstate",   64'(new_pstate), 64'(m_ps));
         chk(t(cwp_tag), "new_cwp", 64'(new_cwp),   64'(m_cwp));
         chk(t("R12"), "new_gl",   64'(new_gl),     64'(m_gl));
         chk(t(pc_tag), "new_pc",  new_pc,          m_pc);
         chk(t("R11"), "new_npc",  new_npc,         m_npc);
      end
   end

   task automatic scramble();
      cur_pstate = 12'($urandom);
      cur_pc     = {$urandom, $urandom};
      cur_npc    = {$urandom, $urandom};
      tba        = {$urandom, $urandom};
      htba       = {$urandom, $urandom};
   endtask

   task automatic fire(input logic [8:0] tt, input logic [2:0] tl, input logic h,
                       input logic [2:0] cwp, input logic [2:0] cs, input logic [2:0] gl);
      @(negedge clk);
      scramble();
      trap_type = tt; cur_tl = tl; hyper_mode = h;
      cur_cwp = cwp; cur_cansave = cs; cur_gl = gl;
      trap_go = 1'b1;
      @(negedge clk);
      trap_go = 1'b0;
      // idle inputs move without a strobe; outputs must hold (R13)
      scramble();
      trap_type = 9'($urandom); cur_tl = 3'($urandom);
      cur_cwp = 3'($urandom); cur_gl = 3'($urandom);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      fire(9'h024, 3'd0, 1'b0, 3'd0, 3'd0, 3'd0); // R6 wrap below zero
      fire(9'h085, 3'd1, 1'b0, 3'd1, 3'd3, 3'd1); // R7 1-3-2 -> 4
      fire(9'h0BF, 3'd1, 1'b1, 3'd2, 3'd7, 3'd2); // R7 large budget, R10
      fire(9'h0C3, 3'd2, 1'b1, 3'd7, 3'd0, 3'd7); // R8 wrap, R12 wrap
      fire(9'h064, 3'd0, 1'b0, 3'd3, 3'd1, 3'd0); // R5 MMU low edge
      fire(9'h06F, 3'd1, 1'b0, 3'd3, 3'd1, 3'd0); // R5 MMU high edge
      fire(9'h070, 3'd1, 1'b0, 3'd3, 3'd1, 3'd0); // R5 just past MMU
      fire(9'h063, 3'd1, 1'b0, 3'd3, 3'd1, 3'd0); // R5 just before MMU
      fire(9'h008, 3'd2, 1'b0, 3'd4, 3'd2, 3'd3); // R5
      fire(9'h030, 3'd3, 1'b1, 3'd4, 3'd2, 3'd3); // R5
      fire(9'h060, 3'd0, 1'b0, 3'd5, 3'd2, 3'd4); // R5 interrupt globals
      fire(9'h041, 3'd4, 1'b0, 3'd6, 3'd2, 3'd4); // R9 level above one
      fire(9'h100, 3'd5, 1'b0, 3'd6, 3'd2, 3'd5); // R3 red edge
      fire(9'h010, 3'd6, 1'b0, 3'd6, 3'd2, 3'd5); // R2 at max
      fire(9'h010, 3'd7, 1'b1, 3'd6, 3'd2, 3'd5); // R2 above max
      fire(9'h1FF, 3'd0, 1'b1, 3'd1, 3'd2, 3'd6); // R10 level one
      for (int i = 0; i < 400; i++) begin
         logic [8:0] tt;
         case ($urandom % 6)
            0: tt = 9'h024;
            1: tt = 9'h080 | 9'($urandom % 64);
            2: tt = 9'h0C0 | 9'($urandom % 64);
            3: tt = 9'h060 | 9'($urandom % 16);
            default: tt = 9'($urandom);
         endcase
         fire(tt, 3'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
         repeat ($urandom % 3) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule